// File: doc/BRIEF.md
# Lumped-Disturbance State Observer

This block estimates, once per control period, the two lumped disturbance terms that a predictive voltage controller for an LC-filtered inverter needs. It tracks a four-element augmented state: filter inductor current, filter capacitor voltage and two disturbance terms. The disturbance terms are modelled as constant across one sample. Each update first predicts the state from the previous estimate and from the output level the controller applied in the previous period. It then corrects the prediction with a fixed gain matrix applied to the error between the measured and predicted current and voltage. No load-current sensor is needed. The disturbance terms absorb the unknown load current and any error in the nominal inductance and capacitance, including errors as large as half the nominal value either way.

The nominal model matrix, input vector and correction gain are written into a coefficient register bank before operation. The gains are computed offline. An update starts with a one-cycle `start` strobe. A single time-shared multiply-accumulate unit evaluates the update and saturates after every add. The sequence takes 29 clock cycles with the default sizes, which fits easily inside a 10 µs period. A `sync_clr` input zeroes the estimates. `est_valid` pulses once when the new disturbance outputs are settled.

The controller is a five-state machine:
- S_IDLE waits for `start` (transition *launch*).
- S_PRED performs 20 MAC steps and leaves after the last column of the last row (transition *predicted*).
- S_ERR forms the two measurement errors in one cycle (transition *errors_ready*).
- S_CORR performs 8 MAC steps and leaves after the last gain of the last row (transition *corrected*).
- S_DONE raises `est_valid` for one cycle and returns to S_IDLE (transition *retire*).

The *abort* transition takes every state back to S_IDLE whenever `sync_clr` is high.

Top module: `lumped_dist_observer`

## Requirements
- R1: After reset all four state estimates are zero, `dist_a` and `dist_b` read 0 and `est_valid` is low.
- R2: Every MAC step computes coef×operand as a signed product. It shifts the product arithmetically right by FRAC (floor), adds it to the signed DW-bit accumulator and clamps the sum to [−2^(DW−1), 2^(DW−1)−1].
- R3: The prediction for row r starts from 0 and accumulates A[r][c]×x[c] for c = 0..3, then B[r]×lvl. A[r][c] is at coefficient address 4r+c and B[r] at address 16+r. `lvl_prev` is a two's complement level, sign-extended, and is captured with the measurements on `start`.
- R4: The errors are e0 = clamp(meas_i − pred0) and e1 = clamp(meas_v − pred1). The new estimate for row r starts from pred[r] and accumulates G[r][0]×e0, then G[r][1]×e1. G[r][j] is at address 20+2r+j.
- R5: `dist_a` is state element 2 and `dist_b` is state element 3. Both hold their value outside the correction phase.
- R6: `est_valid` is high for exactly one cycle, 29 cycles after the clock edge that accepts `start`.
- R7: A `start` pulse during an update in progress has no effect: one valid pulse results, and its result uses the first sample.
- R8: `sync_clr` zeroes all estimates on the next edge and abandons any update in progress without a valid pulse.
- R9: Coefficient writes to addresses 28 to 31 are ignored.
- R10: The corrected state is kept and is the starting estimate of the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of estimates and sequence |
| start | input | 1 | Begin one update; samples the measurements and the level |
| meas_i | input | DW | Measured inductor current, signed |
| meas_v | input | DW | Measured output voltage, signed |
| lvl_prev | input | LW | Level applied in the previous period, signed |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 5 | Coefficient address |
| cfg_data | input | CW | Coefficient value, signed Q(FRAC) |
| dist_a | output | DW | First disturbance estimate |
| dist_b | output | DW | Second disturbance estimate |
| est_valid | output | 1 | One-cycle pulse when new estimates are settled |

## Verification
The assertions watch on every cycle that:
- the disturbance outputs move only during the correction phase or on a clear;
- a clear leaves the outputs at zero with no valid pulse;
- the valid pulse is one cycle wide and always follows the correction phase.

The arithmetic can only be shown by the bench's scenarios. Those scenarios cover:
- prediction with each applied level;
- saturation of the accumulator and of the error;
- state carried from one update to the next;
- the 29-cycle latency;
- a start strobe ignored mid-update;
- an abandoned update;
- writes to unmapped coefficient addresses.

In each scenario the bench compares the outputs against its own fixed-point model.

// File: rtl/obsv_pkg.sv
package obsv_pkg;
    localparam int NX      = 4;
    localparam int NY      = 2;
    localparam int B_BASE  = NX * NX;
    localparam int G_BASE  = B_BASE + NX;
    localparam int NCOEF   = G_BASE + NX * NY;
    localparam int COEF_AW = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRED,
        S_ERR,
        S_CORR,
        S_DONE
    } obsv_state_t;
endpackage

// File: rtl/obsv_coef_bank.sv
module obsv_coef_bank #(
    parameter int CW = 16,
    parameter int NC = 28,
    parameter int AW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [CW-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic signed [CW-1:0] rdata
);
    logic signed [CW-1:0] regs [NC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) regs[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NC; i++) begin
                if (waddr == AW'(i)) regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NC; i++) begin
            if (raddr == AW'(i)) rdata = regs[i];
        end
    end
endmodule

// File: rtl/obsv_mac.sv
module obsv_mac #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12
) (
    input  logic signed [DW-1:0] acc_in,
    input  logic signed [CW-1:0] coef,
    input  logic signed [DW-1:0] opnd,
    output logic signed [DW-1:0] acc_out
);
    localparam int PW = DW + CW;
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [SW-1:0] sum;

    always_comb begin
        prod   = coef * opnd;
        scaled = prod >>> FRAC;
        sum    = {{(SW-DW){acc_in[DW-1]}}, acc_in} + {scaled[PW-1], scaled};
        if (sum > MAXV)
            acc_out = {1'b0, {(DW-1){1'b1}}};
        else if (sum < MINV)
            acc_out = {1'b1, {(DW-1){1'b0}}};
        else
            acc_out = sum[DW-1:0];
    end
endmodule

// File: rtl/lumped_dist_observer.sv
module lumped_dist_observer
    import obsv_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12,
    parameter int LW   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sync_clr,
    input  logic                      start,
    input  logic signed [DW-1:0]      meas_i,
    input  logic signed [DW-1:0]      meas_v,
    input  logic signed [LW-1:0]      lvl_prev,
    input  logic                      cfg_we,
    input  logic [COEF_AW-1:0]        cfg_addr,
    input  logic signed [CW-1:0]      cfg_data,
    output logic signed [DW-1:0]      dist_a,
    output logic signed [DW-1:0]      dist_b,
    output logic                      est_valid
);
    localparam int PCOLS = NX + 1;              // four state columns plus the level column
    localparam logic [2:0] PLAST = 3'(PCOLS - 1);
    localparam logic [1:0] RLAST = 2'(NX - 1);

    obsv_state_t st, st_nx;

    logic signed [DW-1:0] xh  [NX];             // corrected estimates
    logic signed [DW-1:0] pr  [NX];             // predictions
    logic signed [DW-1:0] er  [NY];             // measurement errors
    logic signed [DW-1:0] ym  [NY];             // captured measurements
    logic signed [LW-1:0] lv;
    logic signed [DW-1:0] acc;
    logic [1:0]           row;
    logic [2:0]           col;

    logic [COEF_AW-1:0]   raddr;
    logic signed [CW-1:0] coef;
    logic signed [DW-1:0] opnd;
    logic signed [DW-1:0] mac_out;

    function automatic logic signed [DW-1:0] sub_sat(input logic signed [DW-1:0] a,
                                                     input logic signed [DW-1:0] b);
        logic signed [DW:0] d;
        d = {a[DW-1], a} - {b[DW-1], b};
        if (d[DW] != d[DW-1])
            return d[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        return d[DW-1:0];
    endfunction

    obsv_coef_bank #(.CW(CW), .NC(NCOEF), .AW(COEF_AW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (raddr),
        .rdata (coef)
    );

    obsv_mac #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mac (
        .acc_in  (acc),
        .coef    (coef),
        .opnd    (opnd),
        .acc_out (mac_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (start)                          st_nx = S_PRED;   // launch
            S_PRED: if (row == RLAST && col == PLAST)   st_nx = S_ERR;    // predicted
            S_ERR:                                      st_nx = S_CORR;   // errors_ready
            S_CORR: if (row == RLAST && col == 3'd1)    st_nx = S_DONE;   // corrected
            S_DONE:                                     st_nx = S_IDLE;   // retire
            default:                                    st_nx = S_IDLE;
        endcase
        if (sync_clr) st_nx = S_IDLE;                                     // abort
    end

    // operand selection for the shared MAC
    always_comb begin
        raddr = '0;
        opnd  = '0;
        unique case (st)
            S_PRED: begin
                if (col == PLAST) begin
                    raddr = COEF_AW'(B_BASE) + COEF_AW'(row);
                    opnd  = {{(DW-LW){lv[LW-1]}}, lv};
                end else begin
                    raddr = COEF_AW'({row, col[1:0]});
                    opnd  = xh[col[1:0]];
                end
            end
            S_CORR: begin
                raddr = COEF_AW'(G_BASE) + COEF_AW'({row, col[0]});
                opnd  = er[col[0]];
            end
            default: begin
                raddr = '0;
                opnd  = '0;
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NX; i++) begin
                xh[i] <= '0;
                pr[i] <= '0;
            end
            for (int j = 0; j < NY; j++) begin
                er[j] <= '0;
                ym[j] <= '0;
            end
            lv  <= '0;
            acc <= '0;
            row <= '0;
            col <= '0;
        end else if (sync_clr) begin
            for (int i = 0; i < NX; i++) xh[i] <= '0;
            acc <= '0;
            row <= '0;
            col <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        ym[0] <= meas_i;
                        ym[1] <= meas_v;
                        lv    <= lvl_prev;
                        acc   <= '0;
                        row   <= '0;
                        col   <= '0;
                    end
                end
                S_PRED: begin
                    if (col == PLAST) begin
                        pr[row] <= mac_out;
                        acc     <= '0;
                        col     <= '0;
                        row     <= row + 2'd1;
                    end else begin
                        acc <= mac_out;
                        col <= col + 3'd1;
                    end
                end
                S_ERR: begin
                    er[0] <= sub_sat(ym[0], pr[0]);
                    er[1] <= sub_sat(ym[1], pr[1]);
                    acc   <= pr[0];
                    row   <= '0;
                    col   <= '0;
                end
                S_CORR: begin
                    if (col == 3'd1) begin
                        xh[row] <= mac_out;
                        acc     <= pr[row + 2'd1];
                        col     <= '0;
                        row     <= row + 2'd1;
                    end else begin
                        acc <= mac_out;
                        col <= 3'd1;
                    end
                end
                S_DONE: begin
                    acc <= '0;
                end
                default: begin
                    acc <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        dist_a    = xh[2];
        dist_b    = xh[3];
        est_valid = (st == S_DONE);
    end
endmodule

// File: rtl/obsv_checker.sv
module obsv_checker
    import obsv_pkg::*;
#(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync_clr,
    input logic signed [DW-1:0] dist_a,
    input logic signed [DW-1:0] dist_b,
    input logic                 est_valid,
    input obsv_state_t          st
);
    // R5: outputs move only during correction or on a clear
    a_r5_hold_outside_corr: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_CORR && !sync_clr) |=> ($stable(dist_a) && $stable(dist_b)));

    // R8: a clear zeroes the outputs and suppresses the valid pulse
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (dist_a == '0 && dist_b == '0 && !est_valid));

    // R6: the valid pulse is one cycle wide
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |=> !est_valid);

    // R6: the valid pulse always follows the correction phase
    a_r6_after_corr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(est_valid) |-> $past(st == S_CORR));
endmodule

bind lumped_dist_observer obsv_checker #(.DW(DW)) u_obsv_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_clr  (sync_clr),
    .dist_a    (dist_a),
    .dist_b    (dist_b),
    .est_valid (est_valid),
    .st        (st)
);

// File: tb/tb_lumped_dist_observer.sv
module tb_lumped_dist_observer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16, CW = 16, FRAC = 12, LW = 3;
    localparam int LAT = 29;
    localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (DW-1));

    logic clk = 0, rst_n = 0, sync_clr = 0, start = 0, cfg_we = 0;
    logic signed [DW-1:0] meas_i = 0, meas_v = 0;
    logic signed [LW-1:0] lvl_prev = 0;
    logic [4:0] cfg_addr = 0;
    logic signed [CW-1:0] cfg_data = 0;
    logic signed [DW-1:0] dist_a, dist_b;
    logic est_valid;

    int checks = 0, failures = 0;
    longint mc [28];
    longint mx [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    lumped_dist_observer #(.DW(DW), .CW(CW), .FRAC(FRAC), .LW(LW)) dut (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .start(start),
        .meas_i(meas_i), .meas_v(meas_v), .lvl_prev(lvl_prev),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .dist_a(dist_a), .dist_b(dist_b), .est_valid(est_valid));

    function automatic longint clampv(longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    // R2 arithmetic model
    function automatic longint mac_m(longint acc, longint a, longint x);
        longint p;
        p = (a * x) >>> FRAC;
        return clampv(acc + p);
    endfunction

    // R3/R4/R10 model of one update
    task automatic model_update(longint yi, longint yv, longint lv);
        longint pr [4];
        longint e0, e1, a;
        for (int r = 0; r < 4; r++) begin
            a = 0;
            for (int c = 0; c < 4; c++) a = mac_m(a, mc[4*r+c], mx[c]);
            pr[r] = mac_m(a, mc[16+r], lv);
        end
        e0 = clampv(yi - pr[0]);
        e1 = clampv(yv - pr[1]);
        for (int r = 0; r < 4; r++) begin
            a = mac_m(pr[r], mc[20+2*r], e0);
            mx[r] = mac_m(a, mc[20+2*r+1], e1);
        end
    endtask

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int addr, longint val);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 5'(addr); cfg_data = CW'(val);
        if (addr < 28) mc[addr] = longint'($signed(CW'(val)));
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic run_update(longint yi, longint yv, longint lv, string tag);
        int n;
        @(negedge clk);
        start = 1; meas_i = DW'(yi); meas_v = DW'(yv); lvl_prev = LW'(lv);
        @(negedge clk);
        start = 0;
        n = 0;
        while (!est_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        model_update(yi, yv, lv);
        chk(n == LAT, "R6 latency", n, LAT);
        chk(dist_a == DW'(mx[2]), {tag, " dist_a"}, dist_a, mx[2]);
        chk(dist_b == DW'(mx[3]), {tag, " dist_b"}, dist_b, mx[3]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nv;
        longint sa, sb;
        longint pi [3];
        longint pv [3];
        for (int i = 0; i < 28; i++) mc[i] = 0;
        for (int i = 0; i < 4; i++) mx[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(dist_a == 0, "R1 dist_a", dist_a, 0);
        chk(dist_b == 0, "R1 dist_b", dist_b, 0);
        chk(est_valid == 0, "R1 valid", est_valid, 0);

        // nominal coefficient set (Q12)
        wr(0, 4000); wr(1, -200); wr(2, -150); wr(3, 0);
        wr(4, 300);  wr(5, 4050); wr(6, 0);    wr(7, -120);
        wr(10, 4096); wr(15, 4096);
        wr(16, 600); wr(17, 20); wr(18, 0); wr(19, -5);
        wr(20, 1500); wr(21, 100); wr(22, 50); wr(23, 1800);
        wr(24, 700); wr(25, -300); wr(26, -250); wr(27, 900);

        // R3/R4/R10: sweep every level against several measurement patterns
        pi[0] = 1000;  pv[0] = -2000;
        pi[1] = -3000; pv[1] = 500;
        pi[2] = 12000; pv[2] = 8000;
        for (int p = 0; p < 3; p++)
            for (int l = -2; l <= 2; l++)
                run_update(pi[p], pv[p], l, "R3 R4 R10 sweep");

        // R5: outputs hold while idle
        sa = dist_a; sb = dist_b;
        repeat (12) @(negedge clk);
        chk(dist_a == DW'(sa), "R5 hold dist_a", dist_a, sa);
        chk(dist_b == DW'(sb), "R5 hold dist_b", dist_b, sb);

        // R9: writes to unmapped addresses are ignored
        for (int a = 28; a < 32; a++) wr(a, 32767);
        run_update(2000, 3000, 1, "R9 unmapped");

        // R7: a second start during an update is ignored
        @(negedge clk);
        start = 1; meas_i = 500; meas_v = -700; lvl_prev = -1;
        @(negedge clk);
        start = 0;
        repeat (9) @(negedge clk);
        start = 1; meas_i = 30000; meas_v = 30000; lvl_prev = 2;
        @(negedge clk);
        start = 0;
        nv = 0;
        for (int t = 0; t < 40; t++) begin
            if (est_valid) nv++;
            @(negedge clk);
        end
        model_update(500, -700, -1);
        chk(nv == 1, "R7 pulse count", nv, 1);
        chk(dist_a == DW'(mx[2]), "R7 dist_a", dist_a, mx[2]);
        chk(dist_b == DW'(mx[3]), "R7 dist_b", dist_b, mx[3]);

        // R8: a clear abandons the update and zeroes estimates
        @(negedge clk);
        start = 1; meas_i = 4000; meas_v = 4000; lvl_prev = 2;
        @(negedge clk);
        start = 0;
        repeat (14) @(negedge clk);
        sync_clr = 1;
        @(negedge clk);
        sync_clr = 0;
        chk(dist_a == 0, "R8 dist_a", dist_a, 0);
        chk(dist_b == 0, "R8 dist_b", dist_b, 0);
        nv = 0;
        for (int t = 0; t < 40; t++) begin
            if (est_valid) nv++;
            @(negedge clk);
        end
        chk(nv == 0, "R8 no pulse", nv, 0);
        for (int i = 0; i < 4; i++) mx[i] = 0;
        run_update(-1500, 2500, 0, "R8 R10 restart");

        // R2: saturation of products, accumulator and errors
        for (int a = 0; a < 16; a++) wr(a, 30000);
        for (int a = 16; a < 20; a++) wr(a, -32768);
        for (int a = 20; a < 28; a++) wr(a, 32767);
        run_update(32767, -32768, 2, "R2 sat");
        run_update(-32768, 32767, -2, "R2 sat");
        run_update(100, 100, 1, "R2 sat");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule